// File: doc/BRIEF.md
# Flag and Interrupt Register Unit

This block holds three 32-bit registers behind a small memory-mapped write/read port: a status flag register, an interrupt mask register and a per-bit trigger-type register. It combines them into one interrupt request line. The surrounding logic raises individual flags through a hardware set vector. Software reads the flags, acknowledges events and chooses which flags may interrupt.

The flag register and the mask register can each be written through three addresses. The first address replaces the value. The second clears every bit written as one. The third sets every bit written as one. Software can therefore acknowledge or enable single bits without a read-modify-write sequence. Byte enables limit any write to the selected byte lanes.

The trigger-type register sets the behaviour of each flag. A flag in level mode requests an interrupt for as long as it is high. A flag in edge mode latches a pending event when it rises. That event stays latched until software acknowledges the flag through the clear address.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset the flag register reads 0x20400000, the mask register reads 0x00000000, the trigger-type register reads 0xFFFFFFFF, and `irq` is low.
- R2: A write to byte offset 0x0C replaces the flag register. A write to 0x18 replaces the mask register. A write to 0x24 replaces the trigger-type register. When no write and no hardware set occurs, the registers hold their values.
- R3: A write to 0x10 (flags) or 0x1C (mask) clears exactly the bits written as one. A clear write never turns any bit on.
- R4: A write to 0x14 (flags) or 0x20 (mask) sets exactly the bits written as one.
- R5: Byte-enable bit i selects data bits 8i+7..8i. Bits in lanes whose enable is zero keep their value in every write mode.
- R6: The flag register reads back at 0x0C, 0x10 and 0x14. The mask register reads back at 0x18, 0x1C and 0x20. The trigger-type register reads back at 0x24. Any other address reads zero.
- R7: A one on `hw_flag_set[i]` makes flag i read one after the next clock edge. This holds even when a software write to the same bit happens in that cycle.
- R8: A flag whose trigger-type bit is 0 (level mode) and whose mask bit is 1 keeps `irq` high while the flag is high. `irq` is low whenever the mask register was zero in the previous cycle.
- R9: A flag whose trigger-type bit is 1 (edge mode) raises the interrupt only through a pending event latched on a 0-to-1 transition made while in edge mode. A flag that is already high raises nothing.
- R10: A latched pending event is dropped only by a clear-address write of a one to its flag bit, and only when no hardware set of that bit happens in the same cycle. A replace write that zeroes the flag leaves the event pending.
- R11: `irq` is registered. A level-mode flag set by hardware at clock edge k shows on `irq` after edge k+1, not after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_be | input | DATA_W/8 (4) | Byte-lane enables of the write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` (combinational) |
| hw_flag_set | input | DATA_W (32) | Per-bit hardware flag set pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can fall in the same clock cycle. The first pair is a hardware set pulse and a software clear-address write to the same flag bit. The bench drives both in one cycle, then reads the flag back as one. It also enables the mask to show that the latched edge event is still pending. The second pair is a hardware set pulse and a replace write of zero. The bench judges this case by reading back the hardware bit. It also checks later that the edge event latched on the other bit survives the replace.

// File: rtl/irqreg_pkg.sv
`timescale 1ns/1ps
// Package irqreg_pkg
// Shared write-mode type and the byte offsets of the register aliases.
// Assumes word-aligned offsets compared on the full address.
package irqreg_pkg;

    typedef enum logic [1:0] {
        WM_NONE    = 2'd0,
        WM_REPLACE = 2'd1,
        WM_CLEAR   = 2'd2,
        WM_SET     = 2'd3
    } wmode_e;

    localparam int OFS_FLAG_REP = 'h0C;
    localparam int OFS_FLAG_CLR = 'h10;
    localparam int OFS_FLAG_SET = 'h14;
    localparam int OFS_MASK_REP = 'h18;
    localparam int OFS_MASK_CLR = 'h1C;
    localparam int OFS_MASK_SET = 'h20;
    localparam int OFS_TRIG     = 'h24;

endpackage

// File: rtl/irqreg_alias.sv
`timescale 1ns/1ps
// Module irqreg_alias
// One register with replace/clear/set write modes and byte-lane enables.
// A hardware set vector is ORed in after the software update, so it wins.
// Assumes mode is WM_NONE whenever no write targets this register.
module irqreg_alias #(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  irqreg_pkg::wmode_e      mode,
    input  logic [DATA_W/8-1:0]     be,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [DATA_W-1:0]       hw_set,
    output logic [DATA_W-1:0]       q
);
    import irqreg_pkg::*;

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] lane_m;
    logic [DATA_W-1:0] wbits;
    logic [DATA_W-1:0] upd;

    // Expand each byte enable over its eight data bits.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_m[l*8 +: 8] = {8{be[l]}};
    end

    assign wbits = wdata & lane_m;

    // Purpose: compute the software-updated value for the active write mode.
    always_comb begin
        unique case (mode)
            WM_REPLACE: upd = (q & ~lane_m) | wbits;
            WM_CLEAR:   upd = q & ~wbits;
            WM_SET:     upd = q | wbits;
            default:    upd = q;
        endcase
    end

    // Purpose: register the update with the hardware set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= upd | hw_set;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == WM_NONE && $past(hw_set) == '0) |-> $stable(q)); // R2
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q & $past(hw_set)) == $past(hw_set))); // R7
    AST_CLEAR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == WM_CLEAR) |-> ((q & ~$past(q) & ~$past(hw_set)) == '0)); // R3

endmodule

// File: rtl/irqreg_gen.sv
`timescale 1ns/1ps
// Module irqreg_gen
// Keeps per-bit edge-pending state and forms the registered interrupt.
// Assumes flag_q is the registered flag value. Edges are found against a
// one-cycle-delayed copy, so edge events latch one cycle after the flag.
module irqreg_gen #(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] FLAG_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   flag_q,
    input  logic [DATA_W-1:0]   mask_q,
    input  logic [DATA_W-1:0]   edge_sel,
    input  logic                clr_wr,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   hw_set,
    output logic                irq
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] flag_prev;
    logic [DATA_W-1:0] pend;
    logic [DATA_W-1:0] lane_m;
    logic [DATA_W-1:0] pclr;
    logic [DATA_W-1:0] rise;
    logic [DATA_W-1:0] active;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_m[l*8 +: 8] = {8{be[l]}};
    end

    // Acknowledge only where no hardware set arrives in the same cycle.
    assign pclr   = clr_wr ? (wdata & lane_m & ~hw_set) : '0;
    assign rise   = flag_q & ~flag_prev & edge_sel;
    assign active = mask_q & ((edge_sel & pend) | (~edge_sel & flag_q));

    // Purpose: delayed flag copy used for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_prev <= FLAG_RST;
        else        flag_prev <= flag_q;
    end

    // Purpose: latch edge events, dropping those acknowledged this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend | rise) & ~pclr;
    end

    // Purpose: register the combined interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |active;
    end

    AST_PEND_ONLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & ~$past(pend) & ~$past(edge_sel)) == '0)); // R9
    AST_PEND_DROP_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(pend) & ~pend & ~$past(pclr)) == '0)); // R10
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mask_q) == '0) |-> !irq); // R8

endmodule

// File: rtl/irq_flag_unit.sv
`timescale 1ns/1ps
// Module irq_flag_unit
// Top of the flag/mask/trigger-type register unit. Decodes the aliases,
// muxes read data and drives the registered interrupt request.
// Assumes one access per cycle; reads are combinational from bus_addr.
module irq_flag_unit #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [DATA_W-1:0]   hw_flag_set,
    output logic                irq
);
    import irqreg_pkg::*;

    localparam logic [DATA_W-1:0] FLAG_RST = DATA_W'(32'h2040_0000);
    localparam logic [DATA_W-1:0] MASK_RST = '0;
    localparam logic [DATA_W-1:0] TRIG_RST = '1;

    wmode_e flag_mode, mask_mode, trig_mode;
    logic [DATA_W-1:0] flag_q, mask_q, trig_q;

    // Purpose: map the write address onto register and write mode.
    always_comb begin
        flag_mode = WM_NONE;
        mask_mode = WM_NONE;
        trig_mode = WM_NONE;
        if (bus_wr) begin
            unique case (bus_addr)
                ADDR_W'(OFS_FLAG_REP): flag_mode = WM_REPLACE;
                ADDR_W'(OFS_FLAG_CLR): flag_mode = WM_CLEAR;
                ADDR_W'(OFS_FLAG_SET): flag_mode = WM_SET;
                ADDR_W'(OFS_MASK_REP): mask_mode = WM_REPLACE;
                ADDR_W'(OFS_MASK_CLR): mask_mode = WM_CLEAR;
                ADDR_W'(OFS_MASK_SET): mask_mode = WM_SET;
                ADDR_W'(OFS_TRIG):     trig_mode = WM_REPLACE;
                default: ;
            endcase
        end
    end

    irqreg_alias #(.DATA_W(DATA_W), .RST_VAL(FLAG_RST)) u_flag (
        .clk(clk), .rst_n(rst_n), .mode(flag_mode), .be(bus_be),
        .wdata(bus_wdata), .hw_set(hw_flag_set), .q(flag_q)
    );

    irqreg_alias #(.DATA_W(DATA_W), .RST_VAL(MASK_RST)) u_mask (
        .clk(clk), .rst_n(rst_n), .mode(mask_mode), .be(bus_be),
        .wdata(bus_wdata), .hw_set('0), .q(mask_q)
    );

    irqreg_alias #(.DATA_W(DATA_W), .RST_VAL(TRIG_RST)) u_trig (
        .clk(clk), .rst_n(rst_n), .mode(trig_mode), .be(bus_be),
        .wdata(bus_wdata), .hw_set('0), .q(trig_q)
    );

    irqreg_gen #(.DATA_W(DATA_W), .FLAG_RST(FLAG_RST)) u_gen (
        .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .mask_q(mask_q),
        .edge_sel(trig_q), .clr_wr(flag_mode == WM_CLEAR), .be(bus_be),
        .wdata(bus_wdata), .hw_set(hw_flag_set), .irq(irq)
    );

    // Purpose: return the register behind any of its aliases, else zero.
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_FLAG_REP),
            ADDR_W'(OFS_FLAG_CLR),
            ADDR_W'(OFS_FLAG_SET): bus_rdata = flag_q;
            ADDR_W'(OFS_MASK_REP),
            ADDR_W'(OFS_MASK_CLR),
            ADDR_W'(OFS_MASK_SET): bus_rdata = mask_q;
            ADDR_W'(OFS_TRIG):     bus_rdata = trig_q;
            default:               bus_rdata = '0;
        endcase
    end

    AST_RESET_IRQ_LOW: assert property (@(posedge clk)
        !$past(rst_n) |-> !irq); // R1

endmodule

// File: tb/sim_irq_flag_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, and a monitor
// compares them against the design once per clock after the edge.
module sim_irq_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_flag_set = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_flag_set(hw_flag_set), .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    task automatic push(input bit is_irq, input logic [31:0] exp, input string tag);
        item_t it;
        it.is_irq = is_irq;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr_hw(input logic [7:0] a, input logic [3:0] be,
                         input logic [31:0] d, input logic [31:0] hw);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d; hw_flag_set = hw;
        @(negedge clk);
        bus_wr = 1'b0; hw_flag_set = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        wr_hw(a, be, d, 32'h0);
    endtask

    task automatic pulse(input logic [31:0] hw);
        @(negedge clk);
        hw_flag_set = hw;
        @(negedge clk);
        hw_flag_set = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        push(1'b0, exp, tag);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        push(1'b1, {31'b0, exp}, tag);
    endtask

    // Monitor: one queued expectation is judged just after each clock edge.
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h0C, 32'h2040_0000, "R1 flag reset");
        rd(8'h18, 32'h0, "R1 mask reset");
        rd(8'h24, 32'hFFFF_FFFF, "R1 trigger reset");
        chk_irq(1'b0, "R1 irq reset");
        // R6: aliases and unmapped reads
        rd(8'h10, 32'h2040_0000, "R6 flag via clear alias");
        rd(8'h14, 32'h2040_0000, "R6 flag via set alias");
        rd(8'h28, 32'h0, "R6 unmapped");

        // Mask register write modes
        wr(8'h18, 4'hF, 32'h1234_5678);
        rd(8'h20, 32'h1234_5678, "R2 mask replace");
        wr(8'h18, 4'b0101, 32'hAABB_CCDD);
        rd(8'h18, 32'h12BB_56DD, "R5 mask replace lanes 0,2");
        wr(8'h1C, 4'hF, 32'h0000_00FF);
        rd(8'h1C, 32'h12BB_5600, "R3 mask clear");
        wr(8'h20, 4'b0010, 32'hFF00_0F00);
        rd(8'h18, 32'h12BB_5F00, "R4 mask set lane 1");
        chk_irq(1'b0, "R9 high-at-reset flags do not interrupt");

        // Flag register write modes
        wr(8'h18, 4'hF, 32'h0);
        wr(8'h0C, 4'hF, 32'h0);
        rd(8'h14, 32'h0, "R2 flag replace");
        wr(8'h14, 4'hF, 32'h11);
        rd(8'h0C, 32'h11, "R4 flag set");
        wr(8'h10, 4'hF, 32'h01);
        rd(8'h10, 32'h10, "R3 flag clear");
        wr(8'h10, 4'hF, 32'h10);

        // R7: hardware set beats same-cycle acknowledge
        wr(8'h14, 4'hF, 32'h100);
        wr_hw(8'h10, 4'hF, 32'h100, 32'h100);
        rd(8'h0C, 32'h100, "R7 hw set wins over clear");
        wr(8'h18, 4'hF, 32'h100);
        chk_irq(1'b1, "R10 edge event kept after blocked clear");
        wr(8'h10, 4'hF, 32'h100);
        chk_irq(1'b0, "R10 clear alias drops edge event");
        pulse(32'h8);
        rd(8'h0C, 32'h8, "R7 hw pulse sets flag");
        wr_hw(8'h0C, 4'hF, 32'h0, 32'h4);
        rd(8'h0C, 32'h4, "R7 hw set wins over replace");

        // R8/R11: level mode on bit 0
        wr(8'h24, 4'hF, 32'hFFFF_FFFE);
        wr(8'h18, 4'hF, 32'h1);
        chk_irq(1'b0, "R8 level flag low");
        @(negedge clk);
        hw_flag_set = 32'h1;
        push(1'b1, 32'h0, "R11 irq not yet after flag edge");
        @(negedge clk);
        hw_flag_set = 32'h0;
        push(1'b1, 32'h1, "R11 irq one edge after flag");
        chk_irq(1'b1, "R8 level irq holds");
        wr(8'h10, 4'hF, 32'h1);
        chk_irq(1'b0, "R8 level irq drops with flag");

        // R9: a flag raised in level mode is not an edge event later
        wr(8'h24, 4'hF, 32'hFFFF_FFDE);
        wr(8'h18, 4'hF, 32'h0);
        wr(8'h14, 4'hF, 32'h20);
        wr(8'h24, 4'hF, 32'hFFFF_FFFE);
        wr(8'h18, 4'hF, 32'h20);
        chk_irq(1'b0, "R9 already-high flag in edge mode");
        wr(8'h24, 4'hF, 32'hFFFF_FFDE);
        chk_irq(1'b1, "R8 same flag in level mode");
        rd(8'h24, 32'hFFFF_FFDE, "R6 trigger readback");

        // R10: replace write to zero left bit 3 pending
        wr(8'h18, 4'hF, 32'h8);
        chk_irq(1'b1, "R10 pending survives replace write");
        wr(8'h10, 4'hF, 32'h8);
        chk_irq(1'b0, "R10 acknowledge clears pending");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule